// File: doc/BRIEF.md
# Serial Converter Control Core

This block is the digital sequencer of a serially accessed 8-bit multichannel converter. A host selects it with an active-low select, then clocks eight I/O clock cycles. During the first four rising edges it captures the channel number for the next conversion. Over the same eight cycles it shifts out, MSB first, the result of the previous conversion. All control inputs are resynchronised into a free-running system clock domain, and every decision is taken there.

After the eighth falling I/O clock edge the data output is released and the end-of-conversion flag drops. The selected input is then tracked for a further fixed number of system clocks. After that, a behavioural successive-approximation loop converts the held level, which is either the external level word or an internal self-test word. The new result is latched and the flag rises. If the host re-selects the block while a conversion is still running, that conversion is cancelled. The next readout then returns the older result.

Top module: `sadc_ctrl`

## Requirements
- R1: After `cs_n` falls, the block does not respond (data output stays disabled) until the synchronised select has been low for CS_QUAL (3) consecutive system clocks.
- R2: Out of reset `dout_en` is 0 and `eoc` is 1; whenever the select is released, `dout_en` returns to 0.
- R3: The first four rising `io_clk` edges of an access capture `addr_in` MSB first into a 4-bit channel code, which appears on `chan_sel` from the fourth falling edge on.
- R4: Once the select is recognised, `dout` carries bit 7 of the stored result; falling `io_clk` edges 1 to 7 present bits 6 down to 0 in turn.
- R5: On the eighth falling `io_clk` edge, `dout_en` and `eoc` go to 0, and `sample_track` (high since the fourth falling edge) stays high for SAMP_CYC (12) more system clocks.
- R6: Sampling is followed by a conversion of CONV_CYC (20) system clocks, whose 8-bit result equals the level held at the end of sampling.
- R7: `eoc` returns to 1 in the same cycle the new result is stored, and the following readout returns that result.
- R8: A recognised select fall during sampling or conversion cancels it: `eoc` goes to 1, the stored result is unchanged, and the next readout returns the result from before the cancelled access.
- R9: Channel codes 11 to 15 convert the internal self-test word (default 0x80) instead of `ain_level`; codes 0 to 10 convert `ain_level`.
- R10: With the select held low through a conversion, `dout_en` returns to 1 with the new MSB when `eoc` rises, and the next eight I/O clocks form a new access.
- R11: While the select is high, edges on `io_clk` and `addr_in` start no access and no conversion, and they leave the stored result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| io_clk | input | 1 | Host serial clock, at most half the system clock rate |
| addr_in | input | 1 | Serial channel address, MSB first |
| ain_level | input | 8 | Digital stand-in for the level of the channel on `chan_sel` |
| dout | output | 1 | Serial result bit, valid while `dout_en` is 1 |
| dout_en | output | 1 | Output driver enable; 0 means high impedance |
| eoc | output | 1 | End-of-conversion flag |
| chan_sel | output | 4 | Channel code for the input multiplexer |
| sample_track | output | 1 | High while the selected input is being tracked |

## Verification
On every cycle, the assertions check several timing relations. The select must have been low for consecutive cycles before it is recognised. The output driver must turn off after the select is released. The flag may only fall while tracking is active and the driver is off. Tracking must end exactly as the converter becomes busy. The flag may only rise once the converter is idle. The converter's completion pulse lasts a single cycle, and its result never exceeds the held level. The scenarios cover what spans many cycles or needs a reference value. These are the bit order of the readout, the channel code capture, the self-test substitution, back-to-back accesses with the select held low, the cancel that returns the older result, and inputs toggled while unselected.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_SAMP = 2'd2,
        ST_CONV = 2'd3
    } seq_state_e;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stage_d[g] = din;
        end else begin : g_next
            always_comb stage_d[g] = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sadc_cs_qual.sv
module sadc_cs_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int CS_QUAL     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_act,
    output logic cs_go
);
    localparam int            QW    = $clog2(CS_QUAL + 1);
    localparam logic [QW-1:0] QLAST = QW'(CS_QUAL - 1);

    typedef struct packed {
        logic [QW-1:0] cnt;
        logic          act;
        logic          go;
    } qual_t;

    qual_t q, d;
    logic  cs_s;

    sadc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk (clk),
        .rst_n(rst_n),
        .din (cs_n),
        .dout(cs_s)
    );

    always_comb begin
        d    = q;
        d.go = 1'b0;
        if (cs_s) begin
            d.cnt = '0;
            d.act = 1'b0;
        end else if (!q.act) begin
            if (q.cnt == QLAST) begin
                d.act = 1'b1;
                d.go  = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cs_act = q.act;
    assign cs_go  = q.go;

    // R1: recognition needs the select low over the preceding cycles
    p_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.act) |-> ($past(!cs_s) && $past(!cs_s, 2)));
endmodule

// File: rtl/sadc_sar.sv
module sadc_sar #(
    parameter int DW       = 8,
    parameter int CONV_CYC = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [DW-1:0] level,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result
);
    localparam int            CW    = $clog2(CONV_CYC);
    localparam logic [CW-1:0] CLAST = CW'(CONV_CYC - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW-1:0] mask;
        logic [DW-1:0] acc;
        logic [DW-1:0] held;
    } sar_t;

    sar_t          q, d;
    logic [DW-1:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = q.acc | q.mask;
        if (abort) begin
            d.busy = 1'b0;
        end else if (start) begin
            d.busy = 1'b1;
            d.held = level;
            d.acc  = '0;
            d.mask = {1'b1, {(DW-1){1'b0}}};
            d.cnt  = '0;
        end else if (q.busy) begin
            if (q.mask != '0) begin
                if (trial <= q.held) d.acc = trial;
                d.mask = q.mask >> 1;
            end
            if (q.cnt == CLAST) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = q.busy;
    assign done   = q.done;
    assign result = q.acc;

    // R7: completion is a single-cycle event
    p_sar_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    // R6: the approximation never overshoots the held level
    p_sar_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.acc <= q.held));
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl #(
    parameter int          DW          = 8,
    parameter int          AW          = 4,
    parameter int          SYNC_STAGES = 2,
    parameter int          CS_QUAL     = 3,
    parameter int          SAMP_CYC    = 12,
    parameter int          CONV_CYC    = 20,
    parameter int          SELF_CODE   = 11,
    parameter logic [DW-1:0] SELF_WORD = 8'h80
) (
    input  logic          sys_clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          io_clk,
    input  logic          addr_in,
    input  logic [DW-1:0] ain_level,
    output logic          dout,
    output logic          dout_en,
    output logic          eoc,
    output logic [AW-1:0] chan_sel,
    output logic          sample_track
);
    import sadc_pkg::*;

    localparam int             FW        = $clog2(DW + 1);
    localparam int             SW        = $clog2(SAMP_CYC);
    localparam logic [FW-1:0]  RISE_MAX  = FW'(DW);
    localparam logic [FW-1:0]  ADDR_BITS = FW'(AW);
    localparam logic [FW-1:0]  ADDR_LAST = FW'(AW - 1);
    localparam logic [FW-1:0]  FALL_LAST = FW'(DW - 1);
    localparam logic [SW-1:0]  SAMP_LAST = SW'(SAMP_CYC - 1);
    localparam logic [AW-1:0]  SELF_MIN  = AW'(SELF_CODE);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr_sh;
        logic [AW-1:0] chan;
        logic [DW-1:0] out_sh;
        logic [DW-1:0] result;
        logic [FW-1:0] rcnt;
        logic [FW-1:0] fcnt;
        logic [SW-1:0] scnt;
        logic          eoc;
        logic          den;
        logic          track;
        logic          io_prev;
    } seq_t;

    seq_t          q, d;
    logic          io_s, addr_s;
    logic          cs_act, cs_go;
    logic          io_rise, io_fall;
    logic          sar_start, sar_abort, sar_busy, sar_done;
    logic [DW-1:0] sar_res, conv_level;

    sadc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_io_sync (
        .clk  (sys_clk),
        .rst_n(rst_n),
        .din  ({io_clk, addr_in}),
        .dout ({io_s, addr_s})
    );

    sadc_cs_qual #(.SYNC_STAGES(SYNC_STAGES), .CS_QUAL(CS_QUAL)) u_qual (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .cs_act(cs_act),
        .cs_go (cs_go)
    );

    assign conv_level = (q.chan >= SELF_MIN) ? SELF_WORD : ain_level;

    sadc_sar #(.DW(DW), .CONV_CYC(CONV_CYC)) u_sar (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .start (sar_start),
        .abort (sar_abort),
        .level (conv_level),
        .busy  (sar_busy),
        .done  (sar_done),
        .result(sar_res)
    );

    assign io_rise = io_s & ~q.io_prev;
    assign io_fall = ~io_s & q.io_prev;

    always_comb begin
        d         = q;
        d.io_prev = io_s;
        sar_start = 1'b0;
        sar_abort = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cs_go) begin
                    d.st     = ST_XFER;
                    d.den    = 1'b1;
                    d.out_sh = q.result;
                    d.rcnt   = '0;
                    d.fcnt   = '0;
                end
            end
            ST_XFER: begin
                if (!cs_act) begin
                    d.st    = ST_IDLE;
                    d.den   = 1'b0;
                    d.track = 1'b0;
                    d.rcnt  = '0;
                    d.fcnt  = '0;
                end else begin
                    if (io_rise && (q.rcnt < RISE_MAX)) begin
                        d.rcnt = q.rcnt + 1'b1;
                        if (q.rcnt < ADDR_BITS)
                            d.addr_sh = {q.addr_sh[AW-2:0], addr_s};
                    end
                    if (io_fall && (q.fcnt < q.rcnt)) begin
                        d.fcnt = q.fcnt + 1'b1;
                        if (q.fcnt == ADDR_LAST) begin
                            d.chan  = q.addr_sh;
                            d.track = 1'b1;
                        end
                        if (q.fcnt == FALL_LAST) begin
                            d.st   = ST_SAMP;
                            d.den  = 1'b0;
                            d.eoc  = 1'b0;
                            d.scnt = '0;
                        end else begin
                            d.out_sh = {q.out_sh[DW-2:0], 1'b0};
                        end
                    end
                end
            end
            ST_SAMP, ST_CONV: begin
                if (cs_go) begin
                    sar_abort = (q.st == ST_CONV);
                    d.st      = ST_XFER;
                    d.den     = 1'b1;
                    d.eoc     = 1'b1;
                    d.track   = 1'b0;
                    d.out_sh  = q.result;
                    d.rcnt    = '0;
                    d.fcnt    = '0;
                end else if (q.st == ST_SAMP) begin
                    if (q.scnt == SAMP_LAST) begin
                        d.track   = 1'b0;
                        d.st      = ST_CONV;
                        sar_start = 1'b1;
                    end else begin
                        d.scnt = q.scnt + 1'b1;
                    end
                end else if (sar_done) begin
                    d.result = sar_res;
                    d.eoc    = 1'b1;
                    d.rcnt   = '0;
                    d.fcnt   = '0;
                    if (cs_act) begin
                        d.st     = ST_XFER;
                        d.den    = 1'b1;
                        d.out_sh = sar_res;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.eoc <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign dout         = q.den & q.out_sh[DW-1];
    assign dout_en      = q.den;
    assign eoc          = q.eoc;
    assign chan_sel     = q.chan;
    assign sample_track = q.track;

    // R2: releasing the select turns the driver off on the next cycle
    p_hiz_r2: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $fell(cs_act) |=> !dout_en);
    // R5: the flag drops only with the driver off and tracking active
    p_eoc_fall_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $fell(q.eoc) |-> (!q.den && q.track));
    // R6: end of tracking coincides with the converter becoming busy
    p_conv_start_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ($fell(q.track) && (q.st == ST_CONV)) |-> sar_busy);
    // R7: the flag rises only with the converter idle
    p_eoc_rise_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $rose(q.eoc) |-> !sar_busy);
endmodule

// File: tb/sim_sadc_ctrl.sv
`timescale 1ns/1ps
module sim_sadc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       io_clk = 1'b0;
    logic       addr_in = 1'b0;
    logic [7:0] ain_level;
    logic       dout, dout_en, eoc, sample_track;
    logic [3:0] chan_sel;
    logic [7:0] lvl [16];

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    string      tag_q [$];
    logic [7:0] last_res = 8'h00;

    always #2 clk = ~clk;

    assign ain_level = lvl[chan_sel];

    sadc_ctrl u0 (
        .sys_clk     (sys_clk_w),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .io_clk      (io_clk),
        .addr_in     (addr_in),
        .ain_level   (ain_level),
        .dout        (dout),
        .dout_en     (dout_en),
        .eoc         (eoc),
        .chan_sel    (chan_sel),
        .sample_track(sample_track)
    );
    wire sys_clk_w = clk;

    task automatic chk(input string req, input int got, input int expv);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, expv);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] model(input logic [3:0] a);
        return (a >= 4'd11) ? 8'h80 : lvl[a];
    endfunction

    // monitor: pairs each captured byte with the expected one
    initial begin
        forever begin
            wait (got_q.size() > 0 && exp_q.size() > 0);
            chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
        end
    end

    task automatic cs_fall();
        cs_n = 1'b0;
        wcyc(2);
        chk("R1 early", dout_en, 0);
        wcyc(8);
    endtask

    task automatic xfer(input logic [3:0] a, output logic [7:0] got);
        got[7] = dout;
        for (int i = 0; i < 8; i++) begin
            addr_in = (i < 4) ? a[3-i] : 1'b0;
            wcyc(8);
            io_clk = 1'b1;
            wcyc(8);
            io_clk = 1'b0;
            wcyc(8);
            if (i < 7) got[6-i] = dout;
        end
    endtask

    task automatic access(input logic [3:0] a, input bit keep_low, input string tag);
        logic [7:0] got;
        exp_q.push_back(last_res);
        tag_q.push_back(tag);
        if (cs_n) cs_fall();
        chk("R4 driver on", dout_en, 1);
        xfer(a, got);
        got_q.push_back(got);
        chk("R5 eoc low", eoc, 0);
        chk("R5 tracking", sample_track, 1);
        chk("R5 driver off", dout_en, 0);
        chk("R3 channel code", chan_sel, a);
        if (!keep_low) cs_n = 1'b1;
        wcyc(50);
        chk("R7 eoc high", eoc, 1);
        last_res = model(a);
        if (keep_low) begin
            chk("R10 driver back", dout_en, 1);
            chk("R10 new msb", dout, last_res[7]);
        end else begin
            chk("R2 released", dout_en, 0);
        end
    endtask

    initial begin
        logic [7:0] got;
        for (int k = 0; k < 16; k++) lvl[k] = 8'h44 + 8'(k);
        lvl[3] = 8'hA5; lvl[7] = 8'h3C; lvl[14] = 8'h22; lvl[0] = 8'hC3;
        lvl[10] = 8'h7E; lvl[1] = 8'h96; lvl[5] = 8'h5A; lvl[2] = 8'h11;
        lvl[9] = 8'h69;
        wcyc(5);
        rst_n = 1'b1;
        wcyc(3);
        chk("R2 reset eoc", eoc, 1);
        chk("R2 reset driver", dout_en, 0);

        access(4'd3, 1'b0, "R4 first readout");
        access(4'd7, 1'b0, "R6 result A5");
        access(4'd11, 1'b0, "R6 result 3C");
        access(4'd14, 1'b0, "R9 self-test 11");
        access(4'd0, 1'b1, "R9 self-test 14");
        access(4'd10, 1'b1, "R10 back-to-back");
        access(4'd1, 1'b0, "R10 second back-to-back");

        // R8: cancel a running conversion by re-selecting
        exp_q.push_back(last_res);
        tag_q.push_back("R8 readout before cancel");
        cs_fall();
        xfer(4'd5, got);
        got_q.push_back(got);
        chk("R8 eoc low", eoc, 0);
        cs_n = 1'b1;
        wcyc(6);
        cs_n = 1'b0;
        wcyc(10);
        chk("R8 eoc after cancel", eoc, 1);
        chk("R8 driver after cancel", dout_en, 1);
        chk("R8 old msb", dout, last_res[7]);
        access(4'd2, 1'b0, "R8 older result");

        // R11: toggling while unselected has no effect
        for (int k = 0; k < 6; k++) begin
            addr_in = k[0];
            io_clk = 1'b1;
            wcyc(4);
            io_clk = 1'b0;
            wcyc(4);
        end
        wcyc(40);
        chk("R11 eoc", eoc, 1);
        chk("R11 driver", dout_en, 0);
        access(4'd9, 1'b0, "R11 result kept");
        access(4'd4, 1'b0, "R3 final readout");

        wait (got_q.size() == 0);
        wcyc(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule